// File: doc/BRIEF.md
# Repeating Vertical Pulse Pattern Generator

This block drives one vertical transfer clock of an image sensor at the pixel clock rate. A pattern group sets a start level, a few toggle positions, a pattern length in pixels and a repeat count. A strobe starts a region. From then on the output starts at the start level and inverts at each toggle position that is enabled. The pattern repeats until the region ends, and a one-cycle flag then marks the end of the region.

Three timing variants share the same counters. In the plain variant the pattern runs the set number of times, and a line sync cuts the region short if it arrives first. With line sync suppression enabled the pulse train ignores line syncs and runs across as many lines as it needs. This is how charge is flushed from the vertical registers before readout. In the scaled variant each toggle lands at the toggle value times the pattern length, which gives pulses far wider than a line. In that variant the repeat count gives the coarse step at which the region ends.

A region is one train of pulses from one start strobe. Configuration inputs are assumed to stay stable while a region runs. Edge E0 is the clock edge that samples the start strobe. Edge En is the n-th edge after E0. "After En" means the cycle that follows that edge.

Top module: `vpulse_gen`

## Requirements
- R1: While reset is asserted and after it is released, with no start strobe, `vclk_out` is 0 and `region_done` is 0.
- R2: After the edge that samples `region_start`, `vclk_out` equals `cfg_start_pol`, the counters restart and `region_done` is 0. This holds even if a region is running or `line_sync` is high at that edge.
- R3: In plain timing, a toggle value t with 1 <= t <= L-1 (L = pattern length) inverts `vclk_out` at edges E(r*L+t+1), for repetition r = 0, 1, .... Inversions accumulate across repetitions. The output is not restored between repetitions.
- R4: In plain timing, the region completes at edge E(N*L). N is the repeat count, and a count of 0 acts as 1. A toggle that falls on that edge still applies, and `region_done` is high after that edge.
- R5: In plain timing, a toggle value of 0 and a toggle value of L or more never invert the output.
- R6: With suppression off, a `line_sync` sampled high during a running region ends the region at that edge. `region_done` is high in the next cycle, and no toggle applies at that edge. This holds in both timing variants.
- R7: With suppression on, `line_sync` has no effect, and the region runs to its natural end.
- R8: In scaled timing, a toggle value t with 1 <= t <= N inverts the output at edge E(t*L+1), that is, at pixel count t*L after the start. For example, values 2 and 9 with L = 4 land at pixel counts 8 and 36. Values of 0 or above N never fire.
- R9: In scaled timing, the region completes at edge E(N*L+1). A toggle equal to N still applies at that edge.
- R10: A start with pattern length 0 leaves `vclk_out` at `cfg_start_pol`. No region runs and `region_done` never rises.
- R11: `region_done` is high for exactly one cycle per completed or cut region. Afterwards `vclk_out` holds its last level until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_sync | input | 1 | Horizontal line boundary pulse |
| region_start | input | 1 | Starts a region on the next edge |
| cfg_start_pol | input | 1 | Output level at region start |
| cfg_toggle | input | NUM_TOG*TOG_W | Toggle positions, packed NUM_TOG x TOG_W |
| cfg_pat_len | input | LEN_W | Pattern length in pixels (also the scale factor) |
| cfg_rep_cnt | input | REP_W | Repeat count, or the coarse end step in scaled timing |
| cfg_sweep_en | input | 1 | Ignore line sync for this region |
| cfg_mult_en | input | 1 | Scaled toggle placement |
| vclk_out | output | 1 | Vertical clock output |
| region_done | output | 1 | One-cycle end-of-region flag |

## Verification
The bench builds the block with NUM_TOG = 3, TOG_W = 8, LEN_W = 6 and REP_W = 8. At these widths the full-scale pattern length of 63 runs in a few dozen cycles. A toggle on the last pixel of the longest pattern, and scaled regions whose end step equals the largest toggle, also fit in short runs. The narrower fields bring the boundary cases within reach: a line sync that lands exactly on the natural end edge, a repeat count of 0, a pattern length of 1 in scaled timing, and a restart that coincides with a line sync.

// File: rtl/vpulse_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the vertical pulse generator.
// Holds the region phase encoding and the per-cycle control decision bundle.
package vpulse_pkg;

    // Region phase: idle (output held) or running (counters advance)
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } vpg_phase_e;

    // Control decisions made once per pixel clock by the top module
    typedef struct packed {
        logic cut;      // line sync terminates the region
        logic finish;   // natural end of the region
        logic advance;  // coarse counter steps
        logic run;      // fine counter steps
        logic apply;    // toggle hits may invert the output
    } vpg_ctl_t;

endpackage

// File: rtl/vpg_prescale.sv
`timescale 1ns/1ps
// Module: vpg_prescale
// Fine pixel counter that runs from 0 to cfg_len-1 and then wraps.
// In plain timing it is the pixel position inside the pattern. In scaled
// timing it is the prescaler that divides the pixel clock by cfg_len.
// Assumes cfg_len is nonzero whenever run is asserted.
module vpg_prescale #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [LEN_W-1:0] cfg_len,
    output logic [LEN_W-1:0] pix,
    output logic             wrap,
    output logic             pix_zero
);

    logic [LEN_W-1:0] pix_q;

    // Last pixel of a pattern (or of one prescaler period)
    assign wrap     = (pix_q == (cfg_len - LEN_W'(1)));
    // First pixel of a pattern (or of one coarse step)
    assign pix_zero = (pix_q == '0);
    assign pix      = pix_q;

    // Count pixels; wrap to zero at the end of the period; clear on start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else if (clear) begin
            pix_q <= '0;
        end else if (run) begin
            pix_q <= wrap ? '0 : pix_q + LEN_W'(1);
        end
    end

endmodule

// File: rtl/vpg_coarse.sv
`timescale 1ns/1ps
// Module: vpg_coarse
// Coarse counter. In plain timing it counts the repetitions already
// completed. In scaled timing it counts the prescaler periods already
// completed. The top module guarantees that it never advances beyond the
// configured end value, so it needs no saturation.
module vpg_coarse #(
    parameter int REP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [REP_W-1:0] count
);

    logic [REP_W-1:0] count_q;

    assign count = count_q;

    // Step once per wrap of the fine counter; clear on start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (advance) begin
            count_q <= count_q + REP_W'(1);
        end
    end

endmodule

// File: rtl/vpg_toggle_bank.sv
`timescale 1ns/1ps
// Module: vpg_toggle_bank
// One comparator per toggle position. It reports which toggles hit in the
// current cycle and the parity of all hits. A toggle value of zero is
// disabled. In plain timing a toggle hits when the fine count equals its
// value. In scaled timing it hits on the first pixel of the coarse step
// that equals its value. Purely combinational.
module vpg_toggle_bank #(
    parameter int NUM_TOG = 3,
    parameter int TOG_W   = 12,
    parameter int LEN_W   = 10,
    parameter int REP_W   = 12
) (
    input  logic [NUM_TOG-1:0][TOG_W-1:0] cfg_toggle,
    input  logic                          mult_en,
    input  logic [LEN_W-1:0]              pix,
    input  logic                          pix_zero,
    input  logic [REP_W-1:0]              coarse,
    output logic [NUM_TOG-1:0]            hit,
    output logic                          flip
);

    localparam int CMP_A = (TOG_W > LEN_W) ? TOG_W : LEN_W;
    localparam int CMP_W = (CMP_A > REP_W) ? CMP_A : REP_W;

    logic [CMP_W-1:0] pix_w;
    logic [CMP_W-1:0] coarse_w;

    assign pix_w    = CMP_W'(pix);
    assign coarse_w = CMP_W'(coarse);

    for (genvar g = 0; g < NUM_TOG; g++) begin : g_tog
        logic [CMP_W-1:0] tog_w;
        logic             tog_on;
        logic             hit_plain;
        logic             hit_scaled;

        assign tog_w      = CMP_W'(cfg_toggle[g]);
        assign tog_on     = (cfg_toggle[g] != '0);
        // Plain: pixel position inside the pattern equals the toggle value
        assign hit_plain  = (pix_w == tog_w);
        // Scaled: first pixel of the coarse step equal to the toggle value
        assign hit_scaled = pix_zero && (coarse_w == tog_w);
        assign hit[g]     = tog_on && (mult_en ? hit_scaled : hit_plain);
    end

    // An odd number of simultaneous hits inverts the output
    assign flip = ^hit;

endmodule

// File: rtl/vpulse_gen.sv
`timescale 1ns/1ps
// Module: vpulse_gen (top)
// Generates one vertical clock from a pattern group. A start strobe loads
// the start level and clears the counters. Toggle hits then invert the
// output until the region ends. The region ends on the last repetition
// (plain timing), on the configured coarse step (scaled timing), or early
// on a line sync unless sync suppression is set. Assumes the configuration
// is stable while a region runs.
module vpulse_gen #(
    parameter int NUM_TOG = 3,
    parameter int TOG_W   = 12,
    parameter int LEN_W   = 10,
    parameter int REP_W   = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_sync,
    input  logic                          region_start,
    input  logic                          cfg_start_pol,
    input  logic [NUM_TOG-1:0][TOG_W-1:0] cfg_toggle,
    input  logic [LEN_W-1:0]              cfg_pat_len,
    input  logic [REP_W-1:0]              cfg_rep_cnt,
    input  logic                          cfg_sweep_en,
    input  logic                          cfg_mult_en,
    output logic                          vclk_out,
    output logic                          region_done
);
    import vpulse_pkg::*;

    localparam int CNT_W = REP_W + 1;

    vpg_phase_e         phase_q;
    logic               run_active;
    logic [LEN_W-1:0]   pix;
    logic               wrap;
    logic               pix_zero;
    logic [REP_W-1:0]   coarse;
    logic [NUM_TOG-1:0] hit;
    logic               flip;
    logic               last_rep;
    logic               step_reached;
    logic               len_zero;
    vpg_ctl_t           ctl;
    logic               vclk_q;
    logic               done_q;

    assign run_active = (phase_q == PH_RUN);
    assign len_zero   = (cfg_pat_len == '0);

    // Plain timing: this repetition is the last one (a count of 0 acts as 1)
    assign last_rep     = (CNT_W'(coarse) + CNT_W'(1)) >= CNT_W'(cfg_rep_cnt);
    // Scaled timing: the coarse count has reached the end step
    assign step_reached = (coarse >= cfg_rep_cnt);

    // Per-cycle decisions: a cut takes priority over a natural finish
    always_comb begin
        ctl.cut     = run_active && line_sync && !cfg_sweep_en;
        ctl.finish  = run_active && !ctl.cut &&
                      (cfg_mult_en ? (pix_zero && step_reached)
                                   : (wrap && last_rep));
        ctl.run     = run_active && !ctl.cut && !ctl.finish;
        ctl.advance = ctl.run && wrap;
        ctl.apply   = run_active && !ctl.cut;
    end

    vpg_prescale #(
        .LEN_W (LEN_W)
    ) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (region_start),
        .run      (ctl.run),
        .cfg_len  (cfg_pat_len),
        .pix      (pix),
        .wrap     (wrap),
        .pix_zero (pix_zero)
    );

    vpg_coarse #(
        .REP_W (REP_W)
    ) u_coarse (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (region_start),
        .advance (ctl.advance),
        .count   (coarse)
    );

    vpg_toggle_bank #(
        .NUM_TOG (NUM_TOG),
        .TOG_W   (TOG_W),
        .LEN_W   (LEN_W),
        .REP_W   (REP_W)
    ) u_toggles (
        .cfg_toggle (cfg_toggle),
        .mult_en    (cfg_mult_en),
        .pix        (pix),
        .pix_zero   (pix_zero),
        .coarse     (coarse),
        .hit        (hit),
        .flip       (flip)
    );

    // Region phase: enter on start with a nonzero length, leave on end or cut
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else if (region_start) begin
            phase_q <= len_zero ? PH_IDLE : PH_RUN;
        end else if (ctl.cut || ctl.finish) begin
            phase_q <= PH_IDLE;
        end
    end

    // Output level: load on start, invert on an odd number of hits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vclk_q <= 1'b0;
        end else if (region_start) begin
            vclk_q <= cfg_start_pol;
        end else if (ctl.apply && flip) begin
            vclk_q <= ~vclk_q;
        end
    end

    // End-of-region flag: high for one cycle after the ending edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= !region_start && (ctl.cut || ctl.finish);
        end
    end

    assign vclk_out    = vclk_q;
    assign region_done = done_q;

endmodule

// File: rtl/vpulse_gen_chk.sv
`timescale 1ns/1ps
// Module: vpulse_gen_chk
// Property checker bound into vpulse_gen. It watches the ports and the
// running-phase flag.
module vpulse_gen_chk #(
    parameter int LEN_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_sync,
    input logic             region_start,
    input logic             cfg_start_pol,
    input logic             cfg_sweep_en,
    input logic [LEN_W-1:0] cfg_pat_len,
    input logic             vclk_out,
    input logic             region_done,
    input logic             active
);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        region_done |=> !region_done);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !region_start) |=> $stable(vclk_out));

    // R2
    start_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        region_start |=> (vclk_out == $past(cfg_start_pol)) && !region_done);

    // R6
    cut_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && line_sync && !cfg_sweep_en && !region_start)
            |=> (region_done && !active));

    // R10
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region_start && cfg_pat_len == '0) |=> (!active && !region_done));

    // R4
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        region_done |-> ($past(active) && !active));

endmodule

bind vpulse_gen vpulse_gen_chk #(.LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_sync     (line_sync),
    .region_start  (region_start),
    .cfg_start_pol (cfg_start_pol),
    .cfg_sweep_en  (cfg_sweep_en),
    .cfg_pat_len   (cfg_pat_len),
    .vclk_out      (vclk_out),
    .region_done   (region_done),
    .active        (run_active)
);

// File: tb/vpulse_gen_bench.sv
`timescale 1ns/1ps
// Bench for vpulse_gen: a table of pattern groups is walked by one loop
// against a closed-form model, then directed tests follow.
module vpulse_gen_bench;

    localparam int NUM_TOG = 3;
    localparam int TOG_W   = 8;
    localparam int LEN_W   = 6;
    localparam int REP_W   = 8;

    typedef struct packed {
        bit         pol;
        bit [7:0]   t0;
        bit [7:0]   t1;
        bit [7:0]   t2;
        bit [5:0]   len;
        bit [7:0]   rep;
        bit         sweep;
        bit         mult;
        bit [7:0]   sync;   // edge index that samples line_sync, 0 = none
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'd2,  8'd5, 8'd0, 6'd8,  8'd3, 1'b0, 1'b0, 8'd0},
        '{1'b1, 8'd1,  8'd7, 8'd9, 6'd8,  8'd2, 1'b0, 1'b0, 8'd0},
        '{1'b0, 8'd3,  8'd0, 8'd0, 6'd6,  8'd0, 1'b0, 1'b0, 8'd0},
        '{1'b0, 8'd2,  8'd4, 8'd6, 6'd8,  8'd5, 1'b0, 1'b0, 8'd13},
        '{1'b0, 8'd2,  8'd4, 8'd6, 6'd8,  8'd5, 1'b1, 1'b0, 8'd13},
        '{1'b0, 8'd2,  8'd9, 8'd0, 6'd4,  8'd9, 1'b1, 1'b1, 8'd20},
        '{1'b1, 8'd1,  8'd3, 8'd2, 6'd3,  8'd3, 1'b0, 1'b1, 8'd0},
        '{1'b0, 8'd2,  8'd5, 8'd0, 6'd4,  8'd5, 1'b0, 1'b1, 8'd12},
        '{1'b0, 8'd1,  8'd2, 8'd0, 6'd1,  8'd2, 1'b0, 1'b1, 8'd0},
        '{1'b1, 8'd62, 8'd0, 8'd0, 6'd63, 8'd1, 1'b0, 1'b0, 8'd0},
        '{1'b0, 8'd3,  8'd4, 8'd0, 6'd4,  8'd4, 1'b0, 1'b1, 8'd17},
        '{1'b0, 8'd2,  8'd6, 8'd0, 6'd4,  8'd2, 1'b0, 1'b0, 8'd8}
    };

    logic                          clk;
    logic                          rst_n;
    logic                          line_sync;
    logic                          region_start;
    logic                          cfg_start_pol;
    logic [NUM_TOG-1:0][TOG_W-1:0] cfg_toggle;
    logic [LEN_W-1:0]              cfg_pat_len;
    logic [REP_W-1:0]              cfg_rep_cnt;
    logic                          cfg_sweep_en;
    logic                          cfg_mult_en;
    logic                          vclk_out;
    logic                          region_done;

    int checks;
    int failures;
    bit finished;

    vpulse_gen #(
        .NUM_TOG (NUM_TOG),
        .TOG_W   (TOG_W),
        .LEN_W   (LEN_W),
        .REP_W   (REP_W)
    ) u_vpulse_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_sync     (line_sync),
        .region_start  (region_start),
        .cfg_start_pol (cfg_start_pol),
        .cfg_toggle    (cfg_toggle),
        .cfg_pat_len   (cfg_pat_len),
        .cfg_rep_cnt   (cfg_rep_cnt),
        .cfg_sweep_en  (cfg_sweep_en),
        .cfg_mult_en   (cfg_mult_en),
        .vclk_out      (vclk_out),
        .region_done   (region_done)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Natural end edge of a region, from R4 and R9
    function automatic int nat_end(vec_t v);
        int n;
        if (v.mult) return int'(v.rep) * int'(v.len) + 1;
        n = (v.rep == 0) ? 1 : int'(v.rep);
        return n * int'(v.len);
    endfunction

    // R6: a line sync at or before the natural end cuts the region
    function automatic bit is_cut(vec_t v);
        return !v.sweep && v.sync != 0 && int'(v.sync) <= nat_end(v);
    endfunction

    function automatic int end_edge(vec_t v);
        return is_cut(v) ? int'(v.sync) : nat_end(v);
    endfunction

    function automatic bit edge_ok(vec_t v, int e, int n);
        int lim;
        lim = end_edge(v);
        return e <= n && (e < lim || (e == lim && !is_cut(v)));
    endfunction

    // Expected output after edge En, from R3, R5, R8, R9 and R11
    function automatic bit exp_vclk(vec_t v, int n);
        int cnt;
        int t;
        int reps;
        cnt  = 0;
        reps = (v.rep == 0) ? 1 : int'(v.rep);
        for (int k = 0; k < 3; k++) begin
            t = (k == 0) ? int'(v.t0) : (k == 1) ? int'(v.t1) : int'(v.t2);
            if (t != 0) begin
                if (v.mult) begin
                    if (t <= int'(v.rep) && edge_ok(v, t * int'(v.len) + 1, n))
                        cnt++;
                end else if (t < int'(v.len)) begin
                    for (int r = 0; r < reps; r++)
                        if (edge_ok(v, r * int'(v.len) + t + 1, n)) cnt++;
                end
            end
        end
        return v.pol ^ cnt[0];
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load_cfg(vec_t v);
        cfg_start_pol = v.pol;
        cfg_toggle[0] = v.t0;
        cfg_toggle[1] = v.t1;
        cfg_toggle[2] = v.t2;
        cfg_pat_len   = v.len;
        cfg_rep_cnt   = v.rep;
        cfg_sweep_en  = v.sweep;
        cfg_mult_en   = v.mult;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_vec(vec_t v, int idx);
        string req;
        int    lim;
        if (v.mult) req = "R8/R9";
        else req = "R3/R4/R5";
        if (v.sync != 0) req = v.sweep ? "R7" : "R6";
        lim = end_edge(v);
        load_cfg(v);
        region_start = 1'b1;
        tick();
        region_start = 1'b0;
        check("R2", $sformatf("vec%0d start level", idx), int'(vclk_out), int'(v.pol));
        for (int n = 1; n <= lim + 3; n++) begin
            line_sync = (int'(v.sync) == n);
            tick();
            line_sync = 1'b0;
            check(req, $sformatf("vec%0d vclk n=%0d", idx, n),
                  int'(vclk_out), int'(exp_vclk(v, n)));
            // R11: done for exactly one cycle
            check(req, $sformatf("vec%0d done n=%0d", idx, n),
                  int'(region_done), int'(n == lim));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        vec_t d;
        checks        = 0;
        failures      = 0;
        finished      = 1'b0;
        rst_n         = 1'b0;
        line_sync     = 1'b0;
        region_start  = 1'b0;
        cfg_start_pol = 1'b0;
        cfg_toggle    = '0;
        cfg_pat_len   = '0;
        cfg_rep_cnt   = '0;
        cfg_sweep_en  = 1'b0;
        cfg_mult_en   = 1'b0;
        repeat (3) tick();
        // R1: reset state
        check("R1", "vclk in reset", int'(vclk_out), 0);
        check("R1", "done in reset", int'(region_done), 0);
        rst_n = 1'b1;
        repeat (2) tick();
        check("R1", "vclk idle after reset", int'(vclk_out), 0);
        check("R1", "done idle after reset", int'(region_done), 0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], i);
            repeat (2) tick();
        end

        // R10: zero length keeps the start level and never signals done
        d = '{1'b1, 8'd1, 8'd2, 8'd0, 6'd0, 8'd3, 1'b0, 1'b0, 8'd0};
        load_cfg(d);
        region_start = 1'b1;
        tick();
        region_start = 1'b0;
        for (int n = 0; n < 8; n++) begin
            line_sync = (n == 3);
            check("R10", $sformatf("zero len vclk n=%0d", n), int'(vclk_out), 1);
            check("R10", $sformatf("zero len done n=%0d", n), int'(region_done), 0);
            tick();
        end
        line_sync = 1'b0;

        // R2: restart mid-region together with a line sync; start wins
        d = '{1'b0, 8'd2, 8'd0, 8'd0, 6'd8, 8'd5, 1'b0, 1'b0, 8'd0};
        load_cfg(d);
        region_start = 1'b1;
        tick();
        region_start = 1'b0;
        repeat (5) tick();
        check("R2", "pre-restart level", int'(vclk_out), 1);
        region_start = 1'b1;
        line_sync    = 1'b1;
        tick();
        region_start = 1'b0;
        line_sync    = 1'b0;
        check("R2", "restart level", int'(vclk_out), 0);
        check("R2", "restart no done", int'(region_done), 0);
        repeat (2) tick();
        check("R2", "restart n=2 level", int'(vclk_out), 0);
        tick();
        check("R2", "restart counters fresh n=3", int'(vclk_out), 1);
        check("R2", "still running no done", int'(region_done), 0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule